// File: doc/BRIEF.md
# Banked Data-Space Address Decoder

This block sits between the load/store path of a small 8-bit processor and its data-side storage. It takes one 8-bit data address per cycle and steers it to exactly one target. The targets are a bank of general RAM, the sixteen memory-mapped working registers, or one of several peripheral windows. When the address falls on an area with no storage, it supplies a constant read value instead.

The lower half of the address space (0x00–0x7F) is the banked area. With banking switched on, a non-stack access goes to the RAM bank named by the segment register. Stack accesses, and every access made while banking is off, go to bank 0. Bank 0 holds only 0x00–0x6F. Its top row 0x70–0x7F reads as 0xFF, so a stack pointer that underflows fetches an obviously bad value. The other banks hold the full 128 bytes. The upper half (0x80–0xFF) decodes the same way whatever the segment value.

The decode is registered: the selects for an access presented before a rising edge appear after that edge and hold for one cycle.

Top module: `data_addr_decoder`

## Requirements
- R1: While reset is high, and in the cycle after any edge where `acc_en` was low, every select (`ram_sel`, `reg_sel`, `per_sel`, `fill_rd`) and every write enable is 0, and `fill_data` is 0x00.
- R2: An access to 0x00–0x6F with banking disabled selects RAM with `ram_bank` = 0 and `ram_off` = address bits 6:0.
- R3: In bank 0, an access to 0x70–0x7F selects no storage. A read raises `fill_rd` with `fill_data` = 0xFF. A write raises no select and no enable.
- R4: With banking enabled and `acc_stack` low, an access to 0x00–0x7F goes to RAM bank `seg`, provided `seg` is below NUM_BANKS. For a nonzero `seg`, this includes offsets 0x70–0x7F.
- R5: An access with `acc_stack` high uses bank 0, whatever the value of `seg` and `bank_en`, and keeps the bank-0 trap row of R3.
- R6: With `bank_en` low, `seg` has no effect on which RAM bank or offset is selected.
- R7: With banking enabled, `acc_stack` low and `seg` at or above NUM_BANKS, an access to 0x00–0x7F is unmapped. A read returns 0xFF on `fill_data`. A write raises nothing.
- R8: An access to 0xF0–0xFF raises `reg_sel` with `reg_idx` = address bits 3:0, independent of `seg` and `bank_en`.
- R9: Peripheral accesses raise `per_sel` and report `per_area` with `per_off` measured from the start of the area. The area codes are 0x90–0xBF → 0, 0xC0–0xCF → 1, 0xD0–0xDF → 2, 0xE9 → 3, 0xEA–0xED → 4, 0xEE → 5, 0xEF → 6.
- R10: An access to 0x80–0x8F or 0xE0–0xE8 is unmapped. A read returns 0xFF. A write raises no select and no enable.
- R11: At most one of `ram_sel`, `reg_sel`, `per_sel`, `fill_rd` is high. `ram_we`, `reg_we` and `per_we` follow `acc_wr` of the access, and only alongside their own select.
- R12: Outputs change only at a rising edge and reflect the access sampled at that edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | An access is presented this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_stack | input | 1 | Access is a stack push or pop |
| bank_en | input | 1 | Banking of the low half is switched on |
| seg | input | 8 | Current segment register value |
| addr | input | 8 | Data-space address |
| ram_sel | output | 1 | RAM access selected |
| ram_we | output | 1 | RAM write |
| ram_bank | output | BANK_W | RAM bank number |
| ram_off | output | 7 | Offset inside the bank |
| reg_sel | output | 1 | Working-register access selected |
| reg_we | output | 1 | Working-register write |
| reg_idx | output | 4 | Working-register index |
| per_sel | output | 1 | Peripheral access selected |
| per_we | output | 1 | Peripheral write |
| per_area | output | 3 | Peripheral area code (R9) |
| per_off | output | 6 | Offset inside the peripheral area |
| fill_rd | output | 1 | Read of an unbacked location |
| fill_data | output | 8 | Read value for unbacked locations |

## Verification
Two of the block's functions can apply to the same access: the stack override and the segment redirection. Both want to pick the bank when `acc_stack` is high while banking is on with a nonzero `seg`. The bench drives exactly that case into the ordinary area and into the 0x70–0x7F trap row. It judges the result by requiring bank 0 in the first case and a 0xFF fill instead of a RAM select in the second. A run of the same addresses with the stack flag low then shows the redirection itself still working.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

    typedef enum logic [2:0] {
        ZONE_IDLE = 3'd0,
        ZONE_VOID = 3'd1,
        ZONE_RAM  = 3'd2,
        ZONE_REG  = 3'd3,
        ZONE_PER  = 3'd4
    } zone_e;

    typedef enum logic [2:0] {
        AREA_EXT   = 3'd0,
        AREA_CTRL  = 3'd1,
        AREA_PORT  = 3'd2,
        AREA_SHIFT = 3'd3,
        AREA_TIMER = 3'd4,
        AREA_CNTL  = 3'd5,
        AREA_PSW   = 3'd6
    } area_e;

    typedef struct packed {
        zone_e       zone;
        area_e       area;
        logic [5:0]  off;
    } hi_dec_t;

    localparam logic [7:0] FILL_BYTE     = 8'hFF;
    localparam logic [2:0] TRAP_ROW      = 3'b111;
    localparam logic [7:0] EXT_BASE      = 8'h90;

    // Decode of the always-visible upper half (bit 7 set).
    function automatic hi_dec_t decode_high(input logic [7:0] a);
        hi_dec_t d;
        d.zone = ZONE_VOID;
        d.area = AREA_EXT;
        d.off  = '0;
        case (a[7:4])
            4'h9, 4'hA, 4'hB: begin
                d.zone = ZONE_PER;
                d.area = AREA_EXT;
                d.off  = 6'(a - EXT_BASE);
            end
            4'hC: begin
                d.zone = ZONE_PER;
                d.area = AREA_CTRL;
                d.off  = {2'b00, a[3:0]};
            end
            4'hD: begin
                d.zone = ZONE_PER;
                d.area = AREA_PORT;
                d.off  = {2'b00, a[3:0]};
            end
            4'hE: begin
                case (a[3:0])
                    4'h9: begin
                        d.zone = ZONE_PER;
                        d.area = AREA_SHIFT;
                    end
                    4'hA, 4'hB, 4'hC, 4'hD: begin
                        d.zone = ZONE_PER;
                        d.area = AREA_TIMER;
                        d.off  = {4'b0000, 2'(a[1:0] - 2'd2)};
                    end
                    4'hE: begin
                        d.zone = ZONE_PER;
                        d.area = AREA_CNTL;
                    end
                    4'hF: begin
                        d.zone = ZONE_PER;
                        d.area = AREA_PSW;
                    end
                    default: d.zone = ZONE_VOID;
                endcase
            end
            4'hF: begin
                d.zone = ZONE_REG;
                d.off  = {2'b00, a[3:0]};
            end
            default: d.zone = ZONE_VOID;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dmap_bank_sel.sv
module dmap_bank_sel
    import dmap_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic [2:0]        row,
    input  logic              stack,
    input  logic              bank_en,
    input  logic [7:0]        seg,
    output logic [BANK_W-1:0] bank,
    output logic              backed
);

    logic trap_row;
    logic use_seg;
    logic seg_ok;

    assign trap_row = (row == TRAP_ROW);

    generate
        if (NUM_BANKS == 1) begin : g_single
            assign use_seg = 1'b0;
            assign seg_ok  = 1'b0;
            assign bank    = '0;
        end else begin : g_multi
            assign use_seg = bank_en && !stack;
            assign seg_ok  = (int'(seg) < NUM_BANKS);
            assign bank    = use_seg ? seg[BANK_W-1:0] : '0;
        end
    endgenerate

    always_comb begin
        if (use_seg) begin
            backed = seg_ok && ((seg != 8'd0) || !trap_row);
        end else begin
            backed = !trap_row;
        end
    end

endmodule

// File: rtl/dmap_high_dec.sv
module dmap_high_dec
    import dmap_pkg::*;
(
    input  logic [7:0] addr,
    output hi_dec_t    dec
);

    always_comb begin
        dec = decode_high(addr);
    end

endmodule

// File: rtl/data_addr_decoder.sv
module data_addr_decoder
    import dmap_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_stack,
    input  logic              bank_en,
    input  logic [7:0]        seg,
    input  logic [7:0]        addr,
    output logic              ram_sel,
    output logic              ram_we,
    output logic [BANK_W-1:0] ram_bank,
    output logic [6:0]        ram_off,
    output logic              reg_sel,
    output logic              reg_we,
    output logic [3:0]        reg_idx,
    output logic              per_sel,
    output logic              per_we,
    output logic [2:0]        per_area,
    output logic [5:0]        per_off,
    output logic              fill_rd,
    output logic [7:0]        fill_data
);

    logic [BANK_W-1:0] bank_c;
    logic              backed_c;
    hi_dec_t           hi_c;
    zone_e             zone_c;

    dmap_bank_sel #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_bank (
        .row     (addr[6:4]),
        .stack   (acc_stack),
        .bank_en (bank_en),
        .seg     (seg),
        .bank    (bank_c),
        .backed  (backed_c)
    );

    dmap_high_dec u_high (
        .addr (addr),
        .dec  (hi_c)
    );

    always_comb begin
        if (!acc_en) begin
            zone_c = ZONE_IDLE;
        end else if (addr[7]) begin
            zone_c = hi_c.zone;
        end else begin
            zone_c = backed_c ? ZONE_RAM : ZONE_VOID;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_sel   <= 1'b0;
            ram_we    <= 1'b0;
            ram_bank  <= '0;
            ram_off   <= '0;
            reg_sel   <= 1'b0;
            reg_we    <= 1'b0;
            reg_idx   <= '0;
            per_sel   <= 1'b0;
            per_we    <= 1'b0;
            per_area  <= '0;
            per_off   <= '0;
            fill_rd   <= 1'b0;
            fill_data <= '0;
        end else begin
            ram_sel   <= (zone_c == ZONE_RAM);
            ram_we    <= (zone_c == ZONE_RAM) && acc_wr;
            ram_bank  <= bank_c;
            ram_off   <= addr[6:0];
            reg_sel   <= (zone_c == ZONE_REG);
            reg_we    <= (zone_c == ZONE_REG) && acc_wr;
            reg_idx   <= hi_c.off[3:0];
            per_sel   <= (zone_c == ZONE_PER);
            per_we    <= (zone_c == ZONE_PER) && acc_wr;
            per_area  <= hi_c.area;
            per_off   <= hi_c.off;
            fill_rd   <= (zone_c == ZONE_VOID) && !acc_wr;
            fill_data <= ((zone_c == ZONE_VOID) && !acc_wr) ? FILL_BYTE : 8'h00;
        end
    end

endmodule

// File: rtl/data_addr_decoder_chk.sv
module data_addr_decoder_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_en,
    input logic              acc_wr,
    input logic              acc_stack,
    input logic              bank_en,
    input logic [7:0]        seg,
    input logic [7:0]        addr,
    input logic              ram_sel,
    input logic              ram_we,
    input logic [BANK_W-1:0] ram_bank,
    input logic              reg_sel,
    input logic              reg_we,
    input logic [3:0]        reg_idx,
    input logic              per_sel,
    input logic              per_we,
    input logic              fill_rd,
    input logic [7:0]        fill_data
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(acc_en)) |->
        !(ram_sel || reg_sel || per_sel || fill_rd || ram_we || reg_we || per_we));

    assert_stack_bank0_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_en && acc_stack) && ram_sel) |-> (ram_bank == '0));

    assert_nobank_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_en && !bank_en) && ram_sel) |-> (ram_bank == '0));

    assert_seg_range_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_en && bank_en && !acc_stack && !addr[7] &&
                              (int'(seg) >= NUM_BANKS))) |-> !ram_sel);

    assert_high_not_ram_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_en && addr[7])) |-> !ram_sel);

    assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_en && !acc_wr && (addr[7:4] == 4'h8))) |->
        (fill_rd && (fill_data == 8'hFF)));

    assert_one_target_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_sel, reg_sel, per_sel, fill_rd}));

    assert_we_from_write_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (ram_we || reg_we || per_we)) |-> $past(acc_en && acc_wr));

    assert_reg_latency_R12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_en && (addr[7:4] == 4'hF))) |->
        (reg_sel && (reg_idx == $past(addr[3:0]))));

endmodule

bind data_addr_decoder data_addr_decoder_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_stack (acc_stack),
    .bank_en   (bank_en),
    .seg       (seg),
    .addr      (addr),
    .ram_sel   (ram_sel),
    .ram_we    (ram_we),
    .ram_bank  (ram_bank),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .per_sel   (per_sel),
    .per_we    (per_we),
    .fill_rd   (fill_rd),
    .fill_data (fill_data)
);

// File: tb/test_data_addr_decoder.sv
`timescale 1ns/1ps
module test_data_addr_decoder;

    localparam int NB = 4;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_en = 1'b0, acc_wr = 1'b0, acc_stack = 1'b0, bank_en = 1'b0;
    logic [7:0]    seg = 8'h00, addr = 8'h00;
    logic          ram_sel, ram_we, reg_sel, reg_we, per_sel, per_we, fill_rd;
    logic [BW-1:0] ram_bank;
    logic [6:0]    ram_off;
    logic [3:0]    reg_idx;
    logic [2:0]    per_area;
    logic [5:0]    per_off;
    logic [7:0]    fill_data;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    data_addr_decoder #(.NUM_BANKS(NB)) i_data_addr_decoder (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_stack(acc_stack), .bank_en(bank_en), .seg(seg), .addr(addr),
        .ram_sel(ram_sel), .ram_we(ram_we), .ram_bank(ram_bank), .ram_off(ram_off),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_idx(reg_idx),
        .per_sel(per_sel), .per_we(per_we), .per_area(per_area), .per_off(per_off),
        .fill_rd(fill_rd), .fill_data(fill_data)
    );

    // Vector: {en,wr,stk,ben, seg[8], addr[8], sel{ram,reg,per,fill}[4], bank[2], idx[7], area[3], we}
    localparam int NV = 24;
    localparam logic [36:0] VECS [0:NV-1] = '{
        {4'b1000, 8'h00, 8'h10, 4'b1000, 2'd0, 7'h10, 3'd0, 1'b0}, // R2
        {4'b1100, 8'h00, 8'h6F, 4'b1000, 2'd0, 7'h6F, 3'd0, 1'b1}, // R2
        {4'b1000, 8'h00, 8'h75, 4'b0001, 2'd0, 7'h00, 3'd0, 1'b0}, // R3
        {4'b1100, 8'h00, 8'h7F, 4'b0000, 2'd0, 7'h00, 3'd0, 1'b0}, // R3
        {4'b1001, 8'h02, 8'h75, 4'b1000, 2'd2, 7'h75, 3'd0, 1'b0}, // R4
        {4'b1101, 8'h03, 8'h00, 4'b1000, 2'd3, 7'h00, 3'd0, 1'b1}, // R4
        {4'b1011, 8'h03, 8'h20, 4'b1000, 2'd0, 7'h20, 3'd0, 1'b0}, // R5
        {4'b1011, 8'h01, 8'h7E, 4'b0001, 2'd0, 7'h00, 3'd0, 1'b0}, // R5
        {4'b1000, 8'h03, 8'h30, 4'b1000, 2'd0, 7'h30, 3'd0, 1'b0}, // R6
        {4'b1001, 8'h04, 8'h40, 4'b0001, 2'd0, 7'h00, 3'd0, 1'b0}, // R7
        {4'b1101, 8'h09, 8'h40, 4'b0000, 2'd0, 7'h00, 3'd0, 1'b0}, // R7
        {4'b1001, 8'h02, 8'hFD, 4'b0100, 2'd0, 7'h0D, 3'd0, 1'b0}, // R8
        {4'b1100, 8'h00, 8'hFF, 4'b0100, 2'd0, 7'h0F, 3'd0, 1'b1}, // R8
        {4'b1000, 8'h00, 8'h95, 4'b0010, 2'd0, 7'h05, 3'd0, 1'b0}, // R9
        {4'b1000, 8'h00, 8'hC3, 4'b0010, 2'd0, 7'h03, 3'd1, 1'b0}, // R9
        {4'b1100, 8'h00, 8'hDA, 4'b0010, 2'd0, 7'h0A, 3'd2, 1'b1}, // R9
        {4'b1000, 8'h00, 8'hE9, 4'b0010, 2'd0, 7'h00, 3'd3, 1'b0}, // R9
        {4'b1000, 8'h00, 8'hEC, 4'b0010, 2'd0, 7'h02, 3'd4, 1'b0}, // R9
        {4'b1100, 8'h00, 8'hEE, 4'b0010, 2'd0, 7'h00, 3'd5, 1'b1}, // R9
        {4'b1000, 8'h00, 8'hEF, 4'b0010, 2'd0, 7'h00, 3'd6, 1'b0}, // R9
        {4'b1000, 8'h00, 8'h88, 4'b0001, 2'd0, 7'h00, 3'd0, 1'b0}, // R10
        {4'b1100, 8'h00, 8'hE3, 4'b0000, 2'd0, 7'h00, 3'd0, 1'b0}, // R10
        {4'b1001, 8'h07, 8'hBF, 4'b0010, 2'd0, 7'h2F, 3'd0, 1'b0}, // R9
        {4'b1001, 8'h00, 8'h00, 4'b1000, 2'd0, 7'h00, 3'd0, 1'b0}  // R4
    };
    localparam int VREQ [0:NV-1] = '{2,2,3,3,4,4,5,5,6,7,7,8,8,9,9,9,9,9,9,9,10,10,9,4};

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] ctl, input logic [7:0] s, input logic [7:0] a);
        {acc_en, acc_wr, acc_stack, bank_en} = ctl;
        seg  = s;
        addr = a;
    endtask

    function automatic logic [3:0] sels();
        return {ram_sel, reg_sel, per_sel, fill_rd};
    endfunction

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset holds outputs at zero even with an access presented
        @(negedge clk);
        drive(4'b1100, 8'h00, 8'h10);
        @(negedge clk);
        chk("R1", "sels in reset", int'(sels()), 0);
        chk("R1", "we in reset", int'({ram_we, reg_we, per_we}), 0);
        chk("R1", "fill_data in reset", int'(fill_data), 0);
        rst = 1'b0;
        drive(4'b0000, 8'h00, 8'h00);
        @(negedge clk);
        chk("R1", "sels idle", int'(sels()), 0);

        for (int i = 0; i < NV; i++) begin
            logic [36:0] v;
            string rq;
            v  = VECS[i];
            rq = $sformatf("R%0d", VREQ[i]);
            drive(v[36:33], v[32:25], v[24:17]);
            @(negedge clk);
            chk(rq, $sformatf("v%0d sels", i), int'(sels()), int'(v[16:13]));
            chk(rq, $sformatf("v%0d we", i), int'(ram_we | reg_we | per_we), int'(v[0]));
            chk(rq, $sformatf("v%0d fill", i), int'(fill_data), v[13] ? 8'hFF : 8'h00);
            if (v[16]) begin
                chk(rq, $sformatf("v%0d bank", i), int'(ram_bank), int'(v[12:11]));
                chk(rq, $sformatf("v%0d ram_off", i), int'(ram_off), int'(v[10:4]));
            end
            if (v[15]) chk(rq, $sformatf("v%0d reg_idx", i), int'(reg_idx), int'(v[7:4]));
            if (v[14]) begin
                chk(rq, $sformatf("v%0d area", i), int'(per_area), int'(v[3:1]));
                chk(rq, $sformatf("v%0d per_off", i), int'(per_off), int'(v[9:4]));
            end
        end

        // R5 with R4: stack override and segment redirection on one address
        drive(4'b1011, 8'h02, 8'h75);
        @(negedge clk);
        chk("R5", "stack trap row sels", int'(sels()), 4'b0001);
        drive(4'b1001, 8'h02, 8'h75);
        @(negedge clk);
        chk("R4", "same addr non-stack bank", int'(ram_bank), 2);
        chk("R4", "same addr non-stack sel", int'(ram_sel), 1);

        // R6: changing seg with banking off leaves the decode alone
        drive(4'b1000, 8'h01, 8'h33);
        @(negedge clk);
        drive(4'b1000, 8'hFE, 8'h33);
        @(negedge clk);
        chk("R6", "seg ignored bank", int'(ram_bank), 0);
        chk("R6", "seg ignored sel", int'(ram_sel), 1);

        // R12: outputs hold until the next rising edge
        drive(4'b1000, 8'h00, 8'hF4);
        #1;
        chk("R12", "held before edge", int'(sels()), 4'b1000);
        @(negedge clk);
        chk("R12", "after edge reg_idx", int'(reg_idx), 4);
        chk("R11", "read no we", int'(reg_we), 0);

        // R1: idle after activity
        drive(4'b0100, 8'h00, 8'h88);
        @(negedge clk);
        chk("R1", "idle sels", int'(sels()), 0);
        chk("R1", "idle fill", int'(fill_data), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule